// File: doc/BRIEF.md
# Load result alignment and extension

This combinational unit converts a raw 64-bit memory doubleword into the value a load instruction writes to its destination register. It first moves the addressed byte down to bit 0, using the low three address bits as a byte offset. It then widens the selected field to 64 bits with sign or zero extension, according to the load type.

A destination-kind flag marks loads that target a floating-point register. For those, word and doubleword results skip sign extension and leave the aligned data unchanged. The unit has no clock and no state. It sits between a data read port and a register write port.

Top module: `lda_align_ext`

## Requirements
- R1: `result_o` is computed from `data_i` shifted right by 8 × `addr_lo_i` bits, for offsets 0 to 7. Bit positions vacated at the top by the shift read as zero.
- R2: Load type code 0 (signed byte) sign-extends bits [7:0] of the shifted data to 64 bits.
- R3: Load type code 1 (signed halfword) sign-extends bits [15:0] of the shifted data to 64 bits.
- R4: Load type code 2 (signed word) with `fp_dst_i` = 0 sign-extends bits [31:0] of the shifted data to 64 bits.
- R5: Load type code 2 with `fp_dst_i` = 1 drives the shifted data unchanged, all 64 bits.
- R6: Load type code 3 (doubleword) drives the shifted data unchanged, whatever the value of `fp_dst_i`.
- R7: Load type codes 4, 5 and 6 (unsigned byte, halfword and word) zero-extend bits [7:0], [15:0] and [31:0] of the shifted data.
- R8: Load type code 7 is undefined and drives a result of all zeros.
- R9: `fp_dst_i` has no effect on the result for load type codes 0, 1, 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 64 | Raw doubleword read from memory |
| addr_lo_i | input | 3 | Byte offset of the load within the doubleword |
| kind_i | input | 3 | Load type code (0 to 7) |
| fp_dst_i | input | 1 | Set when the destination is a floating-point register |
| result_o | output | 64 | Aligned and extended load result |

## Verification
Alignment and extension always act together, and the sign bit of a narrow load comes from whichever byte the offset moves into place. The bench therefore pairs every load type with every offset and both flag values, under data patterns whose bytes differ in their top bits. A wrong lane or a wrong sign source then shows up as a different upper result. Every result is compared against a behavioural model that first builds the aligned value byte by byte and then extends it.

// File: rtl/lda_pkg.sv
package lda_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    LK_SB  = 3'd0,
    LK_SH  = 3'd1,
    LK_SW  = 3'd2,
    LK_DW  = 3'd3,
    LK_UB  = 3'd4,
    LK_UH  = 3'd5,
    LK_UW  = 3'd6,
    LK_BAD = 3'd7
  } load_kind_e;
endpackage

// File: rtl/lda_shift.sv
module lda_shift #(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / lda_pkg::BYTE_W,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] shifted_o
);
  localparam int BW = lda_pkg::BYTE_W;

  // one byte-lane mux per output lane; lanes past the top fill with zero
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_comb begin
      shifted_o[g*BW +: BW] = '0;
      for (int j = 0; j < NB; j++) begin
        if (int'(off_i) == j && (g + j) < NB)
          shifted_o[g*BW +: BW] = data_i[((g + j) % NB)*BW +: BW];
      end
    end
  end

  always_comb begin
    AST_LOW_BYTE: assert (shifted_o[BW-1:0] == data_i[{off_i, 3'b000} +: BW]); // R1
    AST_TOP_FILL: assert ((shifted_o >> (DATA_W - BW*int'(off_i))) == '0 || off_i == '0); // R1
  end
endmodule

// File: rtl/lda_extend.sv
module lda_extend #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]     src_i,
  input  lda_pkg::load_kind_e   kind_i,
  input  logic                  fp_dst_i,
  output logic [DATA_W-1:0]     res_o
);
  import lda_pkg::*;

  always_comb begin
    unique case (kind_i)
      LK_SB:   res_o = {{(DATA_W-8){src_i[7]}}, src_i[7:0]};
      LK_SH:   res_o = {{(DATA_W-16){src_i[15]}}, src_i[15:0]};
      LK_SW:   res_o = fp_dst_i ? src_i : {{(DATA_W-32){src_i[31]}}, src_i[31:0]};
      LK_DW:   res_o = src_i;
      LK_UB:   res_o = {{(DATA_W-8){1'b0}}, src_i[7:0]};
      LK_UH:   res_o = {{(DATA_W-16){1'b0}}, src_i[15:0]};
      LK_UW:   res_o = {{(DATA_W-32){1'b0}}, src_i[31:0]};
      default: res_o = '0;
    endcase
  end

  always_comb begin
    AST_SB_SIGN: assert (kind_i != LK_SB || res_o[DATA_W-1:8] == {(DATA_W-8){src_i[7]}}); // R2
    AST_SH_SIGN: assert (kind_i != LK_SH || res_o[DATA_W-1:16] == {(DATA_W-16){src_i[15]}}); // R3
    AST_SW_SIGN: assert (kind_i != LK_SW || fp_dst_i || res_o[DATA_W-1:32] == {(DATA_W-32){src_i[31]}}); // R4
    AST_SW_FP:   assert (kind_i != LK_SW || !fp_dst_i || res_o == src_i); // R5
    AST_DW_PASS: assert (kind_i != LK_DW || res_o == src_i); // R6
    AST_UNS_TOP: assert (!(kind_i inside {LK_UB, LK_UH, LK_UW}) || res_o[DATA_W-1:32] == '0); // R7
    AST_BAD_ZERO: assert (kind_i != LK_BAD || res_o == '0); // R8
  end
endmodule

// File: rtl/lda_align_ext.sv
module lda_align_ext #(
  parameter int DATA_W = 64,
  localparam int OFF_W = $clog2(DATA_W / lda_pkg::BYTE_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [2:0]        kind_i,
  input  logic              fp_dst_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] aligned;
  lda_pkg::load_kind_e kind;

  assign kind = lda_pkg::load_kind_e'(kind_i);

  lda_shift #(.DATA_W(DATA_W)) u_shift (
    .data_i   (data_i),
    .off_i    (addr_lo_i),
    .shifted_o(aligned)
  );

  lda_extend #(.DATA_W(DATA_W)) u_extend (
    .src_i   (aligned),
    .kind_i  (kind),
    .fp_dst_i(fp_dst_i),
    .res_o   (result_o)
  );

  always_comb begin
    AST_DW_ZERO_OFF: assert (!(kind_i == 3'd3 && addr_lo_i == '0) || result_o == data_i); // R6
  end
endmodule

// File: tb/lda_align_ext_tb.sv
module lda_align_ext_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] data_i;
  logic [2:0]  addr_lo_i;
  logic [2:0]  kind_i;
  logic        fp_dst_i;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  lda_align_ext u_dut (
    .data_i   (data_i),
    .addr_lo_i(addr_lo_i),
    .kind_i   (kind_i),
    .fp_dst_i (fp_dst_i),
    .result_o (result_o)
  );

  function automatic logic [63:0] model(input logic [63:0] d, input int off, input int k, input bit fp);
    logic [63:0] s;
    s = '0;
    for (int i = 0; i < 8; i++)
      if (i + off < 8) s[i*8 +: 8] = d[(i+off)*8 +: 8];
    case (k)
      0: return {{56{s[7]}}, s[7:0]};
      1: return {{48{s[15]}}, s[15:0]};
      2: return fp ? s : {{32{s[31]}}, s[31:0]};
      3: return s;
      4: return {56'd0, s[7:0]};
      5: return {48'd0, s[15:0]};
      6: return {32'd0, s[31:0]};
      default: return '0;
    endcase
  endfunction

  function automatic string tag(input int off, input int k, input bit fp);
    if (fp && !(k == 2 || k == 3)) return "R9";
    case (k)
      0: return "R2";
      1: return "R3";
      2: return fp ? "R5" : "R4";
      3: return (off != 0) ? "R1" : "R6";
      7: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic run(input logic [63:0] d, input int off, input int k, input bit fp);
    logic [63:0] exp;
    @(posedge clk);
    #1;
    data_i = d; addr_lo_i = 3'(off); kind_i = 3'(k); fp_dst_i = fp;
    exp = model(d, off, k, fp);
    @(negedge clk);
    checks++;
    if (result_o !== exp) begin
      errors++;
      $display("FAIL %s kind=%0d off=%0d fp=%0d data=%h: got %h exp %h",
               tag(off, k, fp), k, off, fp, d, result_o, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [8];
    pats[0] = 64'h8070_6050_4030_2010;
    pats[1] = 64'h0F8E_7D6C_5B4A_3928;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h0000_0000_0000_0000;
    pats[4] = 64'h80FF_7F00_8001_7FFE;
    pats[5] = 64'h7F80_7F80_7F80_7F80;
    pats[6] = {$urandom(), $urandom()};
    pats[7] = {$urandom(), $urandom()};
    data_i = '0; addr_lo_i = '0; kind_i = '0; fp_dst_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state after reset: zero inputs give zero (R1)
    @(negedge clk);
    checks++;
    if (result_o !== 64'd0) begin
      errors++;
      $display("FAIL R1 idle: got %h exp %h", result_o, 64'd0);
    end
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 8; k++)
        for (int off = 0; off < 8; off++)
          for (int fp = 0; fp < 2; fp++)
            run(pats[p], off, k, fp[0]);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule